// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block connects a small 8-bit processor core to external memory over a narrow pin set. One 8-bit port is shared in time: it first carries the low byte of the address and then becomes the data bus. A second port carries the high address byte. An external transparent latch captures the low byte while the address-latch strobe is high. Program fetches use a dedicated active-low program-store strobe. Data-space reads and writes use separate active-low read and write strobes.

The core raises `req_valid` for one or more clocks while the block is idle. The request carries a 16-bit address, a space select, a read/write flag and write data. The block then runs a fixed-length bus cycle with four phases: idle, address, data and tail. The length of each phase is set by a parameter. When the cycle finishes, the block gives a one-clock `done` pulse, and on a read the captured byte appears on `rdata`. While the synchronous active-low reset is held, the pins sit in a defined safe state.

Top module: `muxbus_ctrl`

## Requirements
- R1: While `rst_n` is low, `addr_latch` is 1, `bus_oe` is 1, `bus_out` is all ones, `addr_hi` is all ones, all three strobes are high, and `busy` and `done` are 0. The first clock edge with `rst_n` low returns the block to idle and clears `rdata` to 0.
- R2: A request is taken on a clock edge where `req_valid` is 1 and `busy` is 0. `busy` is 1 from the next clock. `req_valid` and the request fields are ignored while `busy` is 1.
- R3: The address phase lasts ADDR_CLKS clocks after acceptance. During it, `addr_latch` is 1, `bus_oe` is 1 and `bus_out` equals address bits 7:0.
- R4: The data phase lasts DATA_CLKS clocks and follows the address phase, with `addr_latch` at 0. `addr_hi` equals address bits 15:8 from the first address clock through the last tail clock. No strobe is low while `addr_latch` is 1.
- R5: In a read with `req_prog`=1, `prog_strb_n` is low for exactly the data phase, and `rd_strb_n` and `wr_strb_n` stay high.
- R6: In a read with `req_prog`=0, `rd_strb_n` is low for exactly the data phase, and `prog_strb_n` and `wr_strb_n` stay high.
- R7: During the data phase of a read, `bus_oe` is 0. `bus_in` is sampled at the clock edge that ends the last data-phase clock. The sampled byte is on `rdata` from the first tail clock until the next read's sample.
- R8: In a write (`req_write`=1, `req_prog` ignored), `wr_strb_n` is low for exactly the data phase. `bus_oe` is 1 and `bus_out` equals `req_wdata` through the data phase and the first tail clock. `rdata` is not changed.
- R9: The tail phase lasts TAIL_CLKS clocks. `done` is 1 only on the first tail clock. `busy` is 1 from the first address clock through the last tail clock, and the block is idle on the following clock.
- R10: While idle and out of reset, `addr_latch` is 0, `bus_oe` is 0, `bus_out` is all ones, and all strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 16 | Full bus address |
| req_prog | input | 1 | 1 selects program space (reads only) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Bus cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Last byte read |
| addr_latch | output | 1 | Address-latch strobe, high while low address is on the shared port |
| prog_strb_n | output | 1 | Active-low program-store strobe |
| rd_strb_n | output | 1 | Active-low data read strobe |
| wr_strb_n | output | 1 | Active-low data write strobe |
| bus_out | output | 8 | Shared port output value |
| bus_oe | output | 1 | Shared port output enable |
| bus_in | input | 8 | Shared port input value |
| addr_hi | output | 8 | High address byte port |

## Verification
The checker examines every cycle for the rules that hold regardless of the access in flight:
- at most one strobe is active, and none is active while the latch strobe is high;
- the shared port is released whenever a read strobe is active and driven whenever the write strobe is active;
- write data stays driven and unchanged for one clock after the write strobe rises;
- `done` is a single-clock pulse inside a busy period;
- the high byte stays stable within a cycle, and the data phase never exceeds its length;
- the reset pin state is checked at each edge that sees reset.

Only the bench's scenarios can show the following, because each depends on the request and on when its input arrives:
- a request is taken only when idle;
- the strobe is chosen correctly from the space and direction;
- the read sample is taken on the exact clock, since the input changes every clock;
- back-to-back cycles and a reset in mid-cycle behave correctly.

// File: rtl/muxbus_pkg.sv
// Package: shared types and helpers for the multiplexed bus controller.
// Assumes: nothing; it holds only types and a constant function.
package muxbus_pkg;

    // Phase of one external bus cycle.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_TAIL = 2'd3
    } phase_t;

    // Largest of three phase lengths, used to size the phase counter.
    function automatic int longest3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/muxbus_seq.sv
// Module: muxbus_seq
// Steps a bus cycle through the idle, address, data and tail phases. Each
// non-idle phase lasts its parameterised number of clocks. A request is
// taken only in idle.
// Assumes: every phase length is at least 1; reset is synchronous, active low.
module muxbus_seq
    import muxbus_pkg::*;
#(
    parameter int ADDR_CLKS = 2,
    parameter int DATA_CLKS = 3,
    parameter int TAIL_CLKS = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    output logic   take,
    output phase_t phase,
    output logic   first,
    output logic   last
);

    localparam int LONGEST = longest3(ADDR_CLKS, DATA_CLKS, TAIL_CLKS);
    localparam int CNT_W   = (LONGEST < 2) ? 1 : $clog2(LONGEST);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Pick the final count value of the current phase.
    always_comb begin
        unique case (phase)
            PH_ADDR: limit = CNT_W'(ADDR_CLKS - 1);
            PH_DATA: limit = CNT_W'(DATA_CLKS - 1);
            PH_TAIL: limit = CNT_W'(TAIL_CLKS - 1);
            default: limit = '0;
        endcase
    end

    assign take  = (phase == PH_IDLE) && req_valid;
    assign first = (cnt == '0);
    assign last  = (cnt == limit);

    // Advance the phase counter and move to the next phase on its final clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (req_valid) phase <= PH_ADDR;
                end
                PH_ADDR: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) phase <= PH_DATA;
                end
                PH_DATA: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) phase <= PH_TAIL;
                end
                default: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) phase <= PH_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/muxbus_hold.sv
// Module: muxbus_hold
// Holds the accepted request for the whole bus cycle and captures the read
// byte from the shared port on the final data-phase clock.
// Assumes: take is high only in idle; bus_in is stable around the clock edge.
module muxbus_hold
    import muxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_prog,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_t            phase,
    input  logic              last,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic              prog_q,
    output logic              write_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    // Latch the request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '1;
            prog_q  <= 1'b0;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else if (take) begin
            addr_q  <= req_addr;
            prog_q  <= req_prog;
            write_q <= req_write;
            wdata_q <= req_wdata;
        end
    end

    // Capture the shared port at the edge that closes a read's data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if ((phase == PH_DATA) && last && !write_q) begin
            rdata_q <= bus_in;
        end
    end

endmodule

// File: rtl/muxbus_pins.sv
// Module: muxbus_pins
// Decodes the external pin levels from the current phase and the held
// request. While reset is low, it forces the pins to their safe state.
// Assumes: the address is wider than the data port; outputs are combinational
// from registers and rst_n.
module muxbus_pins
    import muxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     rst_n,
    input  phase_t                   phase,
    input  logic                     first,
    input  logic [ADDR_W-1:0]        addr_q,
    input  logic                     prog_q,
    input  logic                     write_q,
    input  logic [DATA_W-1:0]        wdata_q,
    output logic                     addr_latch,
    output logic                     prog_strb_n,
    output logic                     rd_strb_n,
    output logic                     wr_strb_n,
    output logic [DATA_W-1:0]        bus_out,
    output logic                     bus_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                     busy,
    output logic                     done
);

    // Set the pin levels for the current phase, with reset taking priority.
    always_comb begin
        addr_latch  = 1'b0;
        bus_oe      = 1'b0;
        bus_out     = '1;
        prog_strb_n = 1'b1;
        rd_strb_n   = 1'b1;
        wr_strb_n   = 1'b1;
        busy        = (phase != PH_IDLE);
        done        = 1'b0;
        if (!rst_n) begin
            addr_latch = 1'b1;
            bus_oe     = 1'b1;
            busy       = 1'b0;
        end else begin
            unique case (phase)
                PH_ADDR: begin
                    addr_latch = 1'b1;
                    bus_oe     = 1'b1;
                    bus_out    = addr_q[DATA_W-1:0];
                end
                PH_DATA: begin
                    if (write_q) begin
                        wr_strb_n = 1'b0;
                        bus_oe    = 1'b1;
                        bus_out   = wdata_q;
                    end else if (prog_q) begin
                        prog_strb_n = 1'b0;
                    end else begin
                        rd_strb_n = 1'b0;
                    end
                end
                PH_TAIL: begin
                    done = first;
                    if (write_q && first) begin
                        bus_oe  = 1'b1;
                        bus_out = wdata_q;
                    end
                end
                default: ;
            endcase
        end
    end

    // The high address port shows the held byte, or all ones in reset.
    assign addr_hi = rst_n ? addr_q[ADDR_W-1:DATA_W] : '1;

endmodule

// File: rtl/muxbus_ctrl.sv
// Module: muxbus_ctrl (top)
// Runs fixed-length external bus cycles on a multiplexed low-address/data
// port, with a separate high-address port and latch, program, read and
// write strobes.
// Assumes: ADDR_W > DATA_W; phase lengths of at least 1 clock; the core
// waits for busy to be low before expecting a new request to be taken.
module muxbus_ctrl
    import muxbus_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int ADDR_CLKS = 2,
    parameter int DATA_CLKS = 3,
    parameter int TAIL_CLKS = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_prog,
    input  logic                     req_write,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic                     addr_latch,
    output logic                     prog_strb_n,
    output logic                     rd_strb_n,
    output logic                     wr_strb_n,
    output logic [DATA_W-1:0]        bus_out,
    output logic                     bus_oe,
    input  logic [DATA_W-1:0]        bus_in,
    output logic [ADDR_W-DATA_W-1:0] addr_hi
);

    phase_t            phase;
    logic              take;
    logic              first;
    logic              last;
    logic [ADDR_W-1:0] addr_q;
    logic              prog_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;

    muxbus_seq #(
        .ADDR_CLKS (ADDR_CLKS),
        .DATA_CLKS (DATA_CLKS),
        .TAIL_CLKS (TAIL_CLKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .take      (take),
        .phase     (phase),
        .first     (first),
        .last      (last)
    );

    muxbus_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .req_addr  (req_addr),
        .req_prog  (req_prog),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .phase     (phase),
        .last      (last),
        .bus_in    (bus_in),
        .addr_q    (addr_q),
        .prog_q    (prog_q),
        .write_q   (write_q),
        .wdata_q   (wdata_q),
        .rdata_q   (rdata)
    );

    muxbus_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .rst_n       (rst_n),
        .phase       (phase),
        .first       (first),
        .addr_q      (addr_q),
        .prog_q      (prog_q),
        .write_q     (write_q),
        .wdata_q     (wdata_q),
        .addr_latch  (addr_latch),
        .prog_strb_n (prog_strb_n),
        .rd_strb_n   (rd_strb_n),
        .wr_strb_n   (wr_strb_n),
        .bus_out     (bus_out),
        .bus_oe      (bus_oe),
        .addr_hi     (addr_hi),
        .busy        (busy),
        .done        (done)
    );

endmodule

// File: rtl/muxbus_chk.sv
// Module: muxbus_chk
// Checker bound to muxbus_ctrl. It watches pin-level rules that hold on
// every cycle.
// Assumes: the same parameters as the bound controller.
module muxbus_chk #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int DATA_CLKS = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     busy,
    input logic                     done,
    input logic                     addr_latch,
    input logic                     prog_strb_n,
    input logic                     rd_strb_n,
    input logic                     wr_strb_n,
    input logic [DATA_W-1:0]        bus_out,
    input logic                     bus_oe,
    input logic [ADDR_W-DATA_W-1:0] addr_hi
);

    logic any_strb;
    int   span;

    assign any_strb = !(prog_strb_n && rd_strb_n && wr_strb_n);

    // Count consecutive clocks with a strobe active.
    always_ff @(posedge clk) begin
        if (!rst_n) span <= 0;
        else        span <= any_strb ? span + 1 : 0;
    end

    // Check the safe pin state at every edge that sees reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_PINS: assert (addr_latch && bus_oe && (bus_out == '1) && (addr_hi == '1)
                && prog_strb_n && rd_strb_n && wr_strb_n && !busy && !done); // R1
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!addr_latch && !bus_oe && !any_strb)); // R10
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({prog_strb_n, rd_strb_n, wr_strb_n}) >= 2); // R5
    AST_NO_STROBE_IN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch |-> !any_strb); // R4
    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_strb_n || !rd_strb_n) |-> !bus_oe); // R7
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strb_n |-> bus_oe); // R8
    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_strb_n) |-> (bus_oe && $stable(bus_out))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R9
    AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_hi)); // R4
    AST_DATA_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        span <= DATA_CLKS); // R4

endmodule

bind muxbus_ctrl muxbus_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .DATA_CLKS (DATA_CLKS)
) u_muxbus_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .addr_latch  (addr_latch),
    .prog_strb_n (prog_strb_n),
    .rd_strb_n   (rd_strb_n),
    .wr_strb_n   (wr_strb_n),
    .bus_out     (bus_out),
    .bus_oe      (bus_oe),
    .addr_hi     (addr_hi)
);

// File: tb/test_muxbus_ctrl.sv
`timescale 1ns/1ps
// Bench for muxbus_ctrl. A behavioural model counts clocks into each bus
// cycle, and every output is compared with it on every falling edge.
module test_muxbus_ctrl;

    localparam int A = 2;
    localparam int D = 3;
    localparam int T = 1;
    localparam int TOTAL = A + D + T;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_prog = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  bus_in = 8'h00;
    logic        busy, done, addr_latch, prog_strb_n, rd_strb_n, wr_strb_n, bus_oe;
    logic [7:0]  rdata, bus_out, addr_hi;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Model state.
    int          t = -1;
    logic [15:0] m_addr = 16'hFFFF;
    logic        m_prog = 1'b0;
    logic        m_wr = 1'b0;
    logic [7:0]  m_wd = 8'h00;
    logic [7:0]  m_rd = 8'h00;

    muxbus_ctrl #(.ADDR_CLKS(A), .DATA_CLKS(D), .TAIL_CLKS(T)) i_muxbus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_prog(req_prog), .req_write(req_write), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .addr_latch(addr_latch),
        .prog_strb_n(prog_strb_n), .rd_strb_n(rd_strb_n), .wr_strb_n(wr_strb_n),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .addr_hi(addr_hi)
    );

    initial forever #2.5 clk = ~clk;

    // Reference model: advance on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            t = -1;
            m_addr = 16'hFFFF;
            m_rd = 8'h00;
        end else if (t < 0) begin
            if (req_valid) begin
                t = 0;
                m_addr = req_addr;
                m_prog = req_prog;
                m_wr = req_write;
                m_wd = req_wdata;
            end
        end else if (t == TOTAL - 1) begin
            t = -1;
        end else begin
            if (t == A + D - 1 && !m_wr) m_rd = bus_in;
            t = t + 1;
        end
    end

    task automatic chk(input string tag, input string name, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, name, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model.
    task automatic compare();
        logic el, eo, ep, er, ew, eb, ed;
        logic [7:0] eout, ehi;
        string tb, tl, tbus;
        el = 0; eo = 0; ep = 1; er = 1; ew = 1; eb = 0; ed = 0; eout = 8'hFF;
        ehi = m_addr[15:8];
        tb = "R10"; tl = "R10"; tbus = "R10";
        if (!rst_n) begin
            el = 1; eo = 1; ehi = 8'hFF;
            tb = "R1"; tl = "R1"; tbus = "R1";
        end else if (t >= 0) begin
            eb = 1;
            tb = (t == 0) ? "R2" : "R9";
            if (t < A) begin
                el = 1; eo = 1; eout = m_addr[7:0]; tl = "R3"; tbus = "R3";
            end else if (t < A + D) begin
                tl = "R4";
                if (m_wr) begin
                    ew = 0; eo = 1; eout = m_wd; tbus = "R8";
                end else begin
                    tbus = "R7";
                    if (m_prog) ep = 0; else er = 0;
                end
            end else begin
                tl = "R9"; tbus = "R8";
                ed = (t == A + D);
                if (m_wr && t == A + D) begin eo = 1; eout = m_wd; end
            end
        end
        chk(tl, "addr_latch", 16'(addr_latch), 16'(el));
        chk(tbus, "bus_oe", 16'(bus_oe), 16'(eo));
        chk(tbus, "bus_out", 16'(bus_out), 16'(eout));
        chk(rst_n ? "R5" : "R1", "prog_strb_n", 16'(prog_strb_n), 16'(ep));
        chk(rst_n ? "R6" : "R1", "rd_strb_n", 16'(rd_strb_n), 16'(er));
        chk(rst_n ? "R8" : "R1", "wr_strb_n", 16'(wr_strb_n), 16'(ew));
        chk(tb, "busy", 16'(busy), 16'(eb));
        chk(rst_n ? "R9" : "R1", "done", 16'(done), 16'(ed));
        chk(rst_n ? "R4" : "R1", "addr_hi", 16'(addr_hi), 16'(ehi));
        chk(rst_n ? "R7" : "R1", "rdata", 16'(rdata), 16'(m_rd));
    endtask

    initial begin
        @(posedge clk);
        forever begin
            @(negedge clk);
            if (!finished) compare();
        end
    end

    // The shared port input changes every clock, so a sample taken on the wrong clock shows up.
    initial forever begin
        @(posedge clk);
        #1 bus_in = bus_in + 8'h13;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [15:0] a, input logic p, input logic w, input logic [7:0] d);
        req_valid = 1; req_addr = a; req_prog = p; req_write = w; req_wdata = d;
        step(1);
        req_valid = 0;
        step(TOTAL + 1);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(4);                              // R1 reset state
        rst_n = 1; step(3);                   // R10 idle
        issue(16'h12A5, 1, 0, 8'h00);         // R5 program read
        issue(16'h3C4E, 0, 0, 8'h00);         // R6 data read
        issue(16'h80F1, 0, 1, 8'h5A);         // R8 data write
        issue(16'hFF00, 1, 1, 8'hC3);         // R8 write ignores space select
        // R2: request held while busy must be ignored until idle.
        req_valid = 1; req_addr = 16'h4411; req_prog = 0; req_write = 0;
        step(1);
        req_addr = 16'h9922; req_write = 1; req_wdata = 8'h77;
        step(3);
        req_valid = 0; step(TOTAL + 2);
        // R9: back-to-back requests with the request held high.
        req_valid = 1;
        for (int i = 0; i < 20; i++) begin
            req_addr = 16'(16'h0101 * i + 16'h0A0B);
            req_write = i[1]; req_prog = i[0]; req_wdata = 8'(i * 7);
            step(1);
        end
        req_valid = 0; step(TOTAL + 2);
        // R1: reset in the middle of a write, then a read.
        req_valid = 1; req_addr = 16'h7E3D; req_write = 1; req_wdata = 8'hAB;
        step(1); req_valid = 0; step(2);
        rst_n = 0; step(2);
        rst_n = 1; step(2);
        issue(16'h55AA, 0, 0, 8'h00);         // R7 read after reset
        step(2);
        finish_run();
    end

endmodule